// File: doc/BRIEF.md
# Atomic Read-Modify-Write Bus Controller

This block is the last stage on a data bus before memory. It sits between a CPU request port and the memory-side bus. A plain load or store goes straight through without delay. An atomic request runs as an indivisible sequence. The block first reads the addressed word and keeps a copy. It then combines that copy with the operand from the CPU using the requested operation, and writes the result back to the same address. The CPU receives the word that was in memory before the write.

While an atomic sequence runs, the block holds a lock line on the memory side, and the address stays fixed. No other transaction can come between the read and the write. The memory acknowledge for the read is used inside the block and is not passed on. The CPU sees a single response: the response of the write. If the read fails, that error is the response instead. Atomic requests are accepted at any address. They are never filtered or cached.

Top module: `amo_rmw_ctrl`

## Requirements
- R1: An atomic request (`cpu_stb` with `cpu_atomic`=1) produces exactly two memory strobes, in this order: a read (`mem_we`=0) one cycle after the request, then a write (`mem_we`=1) to the same address one cycle after the read acknowledge.
- R2: The data returned to the CPU with the atomic response is the word captured by the read, not the value written.
- R3: The written word is f(old, operand), where the 4-bit `cpu_op` selects f:
  - 0 swap (the operand)
  - 1 add
  - 2 and
  - 3 or
  - 4 xor
  - 5 signed min
  - 6 signed max
  - 7 unsigned min
  - 8 unsigned max
  - any other code behaves as swap.
- R4: The CPU sees no acknowledge or error for the read. `cpu_ack` pulses exactly once, in the cycle the write acknowledge arrives. With a memory latency of L cycles, that is 2+2L cycles after the request.
- R5: If the read returns `mem_err`, no write is issued. `cpu_err` pulses in that same cycle, carrying the read data, and the block returns to idle.
- R6: `mem_lock` is high from the read strobe cycle through the final response cycle. `mem_addr` does not change while it is high.
- R7: The atomic write drives all byte enables high, whatever `cpu_ben` holds.
- R8: While idle, a non-atomic request reaches the memory bus in the same cycle, with its address, write flag, data and byte enables unchanged. Its response (ack, err, data) returns to the CPU in the same cycle it arrives.
- R9: After reset the block is idle: no memory strobe, lock low, and no CPU response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_stb | input | 1 | One-cycle request strobe from the CPU |
| cpu_atomic | input | 1 | Request is an atomic read-modify-write |
| cpu_op | input | 4 | Atomic operation code (see R3) |
| cpu_we | input | 1 | Write flag for plain requests |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Store data or atomic operand |
| cpu_ben | input | DATA_W/8 | Byte enables for plain requests |
| cpu_rdata | output | DATA_W | Response data to the CPU |
| cpu_ack | output | 1 | Response acknowledge to the CPU |
| cpu_err | output | 1 | Response error to the CPU |
| mem_stb | output | 1 | Memory request strobe |
| mem_we | output | 1 | Memory write flag |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ben | output | DATA_W/8 | Memory byte enables |
| mem_lock | output | 1 | Bus held for an atomic sequence |
| mem_rdata | input | DATA_W | Memory read data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Memory error |

## Verification
A state that fails to return to idle shows at once: the next plain request is never forwarded. It also shows as `mem_lock` staying high after the response cycle. A wrong operand or operation latch shows only at the final write, as a wrong `mem_wdata` and a memory word that differs from the reference. A response path that leaks the read acknowledge shows as a `cpu_ack` L+1 cycles after the request instead of 2+2L. The bench therefore checks the response timing and the lock level on every cycle of every request, and checks the whole memory image after every operation.

// File: rtl/amo_rmw_pkg.sv
package amo_rmw_pkg;

  typedef enum logic [3:0] {
    OP_SWAP = 4'd0,
    OP_ADD  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_MIN  = 4'd5,
    OP_MAX  = 4'd6,
    OP_MINU = 4'd7,
    OP_MAXU = 4'd8
  } amo_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT_RD,
    ST_WRITE,
    ST_WAIT_WR
  } seq_state_e;

endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_rmw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] mem_word,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result
);

  logic s_less;
  logic u_less;

  assign s_less = $signed(mem_word) < $signed(operand);
  assign u_less = mem_word < operand;

  always_comb begin
    case (op)
      OP_ADD:  result = mem_word + operand;
      OP_AND:  result = mem_word & operand;
      OP_OR:   result = mem_word | operand;
      OP_XOR:  result = mem_word ^ operand;
      OP_MIN:  result = s_less ? mem_word : operand;
      OP_MAX:  result = s_less ? operand : mem_word;
      OP_MINU: result = u_less ? mem_word : operand;
      OP_MAXU: result = u_less ? operand : mem_word;
      default: result = operand;  // swap and unused codes
    endcase
  end

endmodule

// File: rtl/amo_seq.sv
module amo_seq
  import amo_rmw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [3:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_operand,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] alu_result,
  output logic [3:0]        op_q,
  output logic [DATA_W-1:0] operand_q,
  output logic              idle,
  output logic              seq_stb,
  output logic              seq_we,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [DATA_W-1:0] seq_wdata,
  output logic [DATA_W-1:0] seq_rdata,
  output logic              seq_ack,
  output logic              seq_err
);

  seq_state_e        state;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] old_q;
  logic [DATA_W-1:0] new_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      op_q      <= '0;
      operand_q <= '0;
      old_q     <= '0;
      new_q     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          addr_q    <= req_addr;
          op_q      <= req_op;
          operand_q <= req_operand;
          state     <= ST_READ;
        end
        ST_READ: state <= ST_WAIT_RD;
        ST_WAIT_RD: begin
          if (mem_err) begin
            state <= ST_IDLE;
          end else if (mem_ack) begin
            old_q <= mem_rdata;
            new_q <= alu_result;
            state <= ST_WRITE;
          end
        end
        ST_WRITE: state <= ST_WAIT_WR;
        ST_WAIT_WR: if (mem_ack || mem_err) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign idle      = (state == ST_IDLE);
  assign seq_stb   = (state == ST_READ) || (state == ST_WRITE);
  assign seq_we    = (state == ST_WRITE);
  assign seq_addr  = addr_q;
  assign seq_wdata = new_q;
  assign seq_rdata = (state == ST_WAIT_RD) ? mem_rdata : old_q;
  assign seq_ack   = (state == ST_WAIT_WR) && mem_ack;
  assign seq_err   = ((state == ST_WAIT_RD) || (state == ST_WAIT_WR)) && mem_err;

  // R6: address held for the whole locked sequence
  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!idle && !$past(idle)) |-> $stable(seq_addr));

  // R1: each strobe lasts one cycle
  assert_single_stb_R1: assert property (@(posedge clk) disable iff (rst)
    seq_stb |=> !seq_stb);

  // R1: a write strobe only follows an acknowledged read
  assert_write_after_read_R1: assert property (@(posedge clk) disable iff (rst)
    (seq_stb && seq_we) |-> ($past(state) == ST_WAIT_RD) && $past(mem_ack));

  // R4: the final acknowledge never coincides with the read acknowledge
  assert_ack_from_write_R4: assert property (@(posedge clk) disable iff (rst)
    seq_ack |-> !$past(mem_ack));

endmodule

// File: rtl/amo_rmw_ctrl.sv
module amo_rmw_ctrl
  import amo_rmw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_stb,
  input  logic                cpu_atomic,
  input  logic [3:0]          cpu_op,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic [DATA_W/8-1:0] cpu_ben,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                cpu_ack,
  output logic                cpu_err,
  output logic                mem_stb,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [DATA_W/8-1:0] mem_ben,
  output logic                mem_lock,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                mem_ack,
  input  logic                mem_err
);

  localparam int BEN_W = DATA_W / 8;

  logic              idle;
  logic              seq_stb;
  logic              seq_we;
  logic              seq_ack;
  logic              seq_err;
  logic [ADDR_W-1:0] seq_addr;
  logic [DATA_W-1:0] seq_wdata;
  logic [DATA_W-1:0] seq_rdata;
  logic [DATA_W-1:0] alu_result;
  logic [DATA_W-1:0] operand_q;
  logic [3:0]        op_q;

  amo_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (cpu_stb && cpu_atomic),
    .req_op      (cpu_op),
    .req_addr    (cpu_addr),
    .req_operand (cpu_wdata),
    .mem_rdata   (mem_rdata),
    .mem_ack     (mem_ack),
    .mem_err     (mem_err),
    .alu_result  (alu_result),
    .op_q        (op_q),
    .operand_q   (operand_q),
    .idle        (idle),
    .seq_stb     (seq_stb),
    .seq_we      (seq_we),
    .seq_addr    (seq_addr),
    .seq_wdata   (seq_wdata),
    .seq_rdata   (seq_rdata),
    .seq_ack     (seq_ack),
    .seq_err     (seq_err)
  );

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .op       (op_q),
    .mem_word (mem_rdata),
    .operand  (operand_q),
    .result   (alu_result)
  );

  always_comb begin
    if (idle) begin
      mem_stb   = cpu_stb && !cpu_atomic;
      mem_we    = cpu_we;
      mem_addr  = cpu_addr;
      mem_wdata = cpu_wdata;
      mem_ben   = cpu_ben;
      cpu_rdata = mem_rdata;
      cpu_ack   = mem_ack;
      cpu_err   = mem_err;
    end else begin
      mem_stb   = seq_stb;
      mem_we    = seq_we;
      mem_addr  = seq_addr;
      mem_wdata = seq_wdata;
      mem_ben   = {BEN_W{1'b1}};
      cpu_rdata = seq_rdata;
      cpu_ack   = seq_ack;
      cpu_err   = seq_err;
    end
  end

  assign mem_lock = !idle;

  // R8: plain requests reach memory in the same cycle, unchanged
  assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
    (!mem_lock && cpu_stb && !cpu_atomic) |-> (mem_stb && mem_addr == cpu_addr && mem_we == cpu_we));

  // R7: locked strobes use every byte lane
  assert_full_ben_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_lock && mem_stb) |-> (mem_ben == {BEN_W{1'b1}}));

  // R9: no locked activity right after reset release
  assert_reset_idle_R9: assert property (@(posedge clk)
    $past(rst) |-> !mem_lock);

endmodule

// File: tb/sim_amo_rmw_ctrl.sv
`timescale 1ns/1ps
module sim_amo_rmw_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_stb = 1'b0, cpu_atomic = 1'b0, cpu_we = 1'b0;
  logic [3:0]  cpu_op = 4'd0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0]  cpu_ben = 4'hF;
  logic [31:0] cpu_rdata;
  logic        cpu_ack, cpu_err;
  logic        mem_stb, mem_we, mem_lock;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_ben;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0, mem_err = 1'b0;

  int checks = 0;
  int fails  = 0;
  int lat    = 1;

  always #2.5 clk = ~clk;

  amo_rmw_ctrl u0 (.*);

  // memory model and reference image
  logic [31:0] arr [16];
  logic [31:0] ref_mem [16];
  int          t = 0;
  logic [31:0] p_addr, p_wd;
  logic        p_we;
  logic [3:0]  p_ben;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    mem_err <= 1'b0;
    if (rst) begin
      t = 0;
    end else begin
      if (mem_stb) begin
        p_addr = mem_addr; p_we = mem_we; p_wd = mem_wdata; p_ben = mem_ben;
        t = lat;
      end
      if (t > 0) begin
        t = t - 1;
        if (t == 0) begin
          if (p_addr[31]) begin
            mem_err   <= 1'b1;
            mem_rdata <= {16'hE000, p_addr[15:0]};
          end else begin
            mem_ack <= 1'b1;
            if (p_we) begin
              for (int b = 0; b < 4; b++)
                if (p_ben[b]) arr[p_addr[5:2]][8*b +: 8] = p_wd[8*b +: 8];
              mem_rdata <= 32'h0;
            end else begin
              mem_rdata <= arr[p_addr[5:2]];
            end
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ref_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    int sa, sb;
    sa = a; sb = b;
    case (op)
      4'd1: return a + b;
      4'd2: return a & b;
      4'd3: return a | b;
      4'd4: return a ^ b;
      4'd5: return (sa < sb) ? a : b;
      4'd6: return (sa > sb) ? a : b;
      4'd7: return (a < b) ? a : b;
      4'd8: return (a > b) ? a : b;
      default: return b;
    endcase
  endfunction

  // one request, compared on every cycle until after its response
  task automatic run_req(input bit atomic, input logic [3:0] op, input bit we,
                         input logic [31:0] addr, input logic [31:0] wd, input logic [3:0] ben);
    int resp_c, nstb;
    bit bad;
    logic [31:0] exp_rd, exp_new;
    bad  = addr[31];
    nstb = 0;
    if (atomic) resp_c = bad ? 1 + lat : 2 + 2 * lat;
    else        resp_c = lat;
    if (bad)             exp_rd = {16'hE000, addr[15:0]};
    else if (!atomic && we) exp_rd = 32'h0;
    else                 exp_rd = ref_mem[addr[5:2]];
    exp_new = atomic ? ref_op(op, exp_rd, wd) : wd;
    @(negedge clk);
    cpu_stb = 1'b1; cpu_atomic = atomic; cpu_op = op; cpu_we = we;
    cpu_addr = addr; cpu_wdata = wd; cpu_ben = ben;
    #1;
    if (!atomic) begin
      chk(mem_stb && mem_addr == addr && mem_we == we && mem_ben == ben && mem_wdata == wd,
          "R8 same-cycle forward", {31'd0, mem_stb}, 32'd1);
      nstb++;
    end else begin
      chk(!mem_stb, "R1 no strobe in request cycle", {31'd0, mem_stb}, 32'd0);
    end
    for (int c = 1; c <= resp_c + 2; c++) begin
      @(negedge clk);
      if (c == 1) begin cpu_stb = 1'b0; cpu_atomic = 1'b0; end
      #1;
      chk(cpu_ack == (c == resp_c && !bad), atomic ? "R4 ack timing" : "R8 ack timing",
          {31'd0, cpu_ack}, {31'd0, (c == resp_c && !bad)});
      chk(cpu_err == (c == resp_c && bad), atomic ? "R5 err timing" : "R8 err timing",
          {31'd0, cpu_err}, {31'd0, (c == resp_c && bad)});
      if (c == resp_c)
        chk(cpu_rdata == exp_rd, atomic ? (bad ? "R5 read data" : "R2 old data") : "R8 data",
            cpu_rdata, exp_rd);
      if (atomic)
        chk(mem_lock == (c <= resp_c), "R6 lock level", {31'd0, mem_lock}, {31'd0, (c <= resp_c)});
      if (mem_stb) begin
        nstb++;
        chk(mem_addr == addr, "R6 address", mem_addr, addr);
        if (atomic && c == 1)
          chk(!mem_we, "R1 read first", {31'd0, mem_we}, 32'd0);
        else if (atomic && c == 2 + lat) begin
          chk(mem_we, "R1 write second", {31'd0, mem_we}, 32'd1);
          chk(mem_ben == 4'hF, "R7 full byte enables", {28'd0, mem_ben}, 32'hF);
          chk(mem_wdata == exp_new, "R3 write value", mem_wdata, exp_new);
        end else
          chk(1'b0, "R1 unexpected strobe", c, 0);
      end
    end
    chk(nstb == (atomic ? (bad ? 1 : 2) : 1), "R1 strobe count", nstb, atomic ? (bad ? 1 : 2) : 1);
    if (!bad) begin
      if (atomic) ref_mem[addr[5:2]] = exp_new;
      else if (we)
        for (int b = 0; b < 4; b++)
          if (ben[b]) ref_mem[addr[5:2]][8*b +: 8] = wd[8*b +: 8];
    end
    for (int i = 0; i < 16; i++)
      chk(arr[i] === ref_mem[i], atomic ? "R3 memory image" : "R8 memory image", arr[i], ref_mem[i]);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      arr[i] = (i * 32'h1357_9BDF) ^ 32'h8000_0003;
      ref_mem[i] = arr[i];
    end
    repeat (3) @(negedge clk);
    chk(!mem_stb && !mem_lock && !cpu_ack && !cpu_err, "R9 reset idle",
        {28'd0, mem_stb, mem_lock, cpu_ack, cpu_err}, 32'd0);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(!mem_stb && !mem_lock && !cpu_ack, "R9 idle after reset",
        {29'd0, mem_stb, mem_lock, cpu_ack}, 32'd0);

    for (int l = 1; l <= 3; l += 2) begin
      lat = l;
      run_req(0, 4'd0, 1, 32'h10, 32'h0000_0010, 4'hF);
      run_req(0, 4'd0, 0, 32'h10, 32'h0, 4'hF);
      run_req(0, 4'd0, 1, 32'h14, 32'hAABB_CCDD, 4'b0101);
      for (int op = 0; op <= 8; op++) begin
        run_req(1, op[3:0], 0, 32'h20 + 4 * op, 32'hFFFF_FF80 + op, 4'h1);
        run_req(1, op[3:0], 1, 32'h04, 32'h0000_0007 * (op + 1), 4'h0);
      end
      run_req(1, 4'd15, 0, 32'h08, 32'h1234_5678, 4'h3);   // unused code acts as swap
      run_req(1, 4'd1, 0, 32'h8000_0040, 32'h1, 4'hF);     // R5 read error
      run_req(0, 4'd0, 0, 32'h8000_0044, 32'h0, 4'hF);     // plain error
      run_req(1, 4'd1, 0, 32'h3C, 32'h0000_0001, 4'hF);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule